// File: doc/BRIEF.md
# Compare-Match Timer Counter Channel

This block is one 16-bit timer/counter channel controlled through a small register interface. Its counter advances on a tick taken from one of eight sources: four prescaled tick lines, a slow 32.768 kHz tick line and three external chain lines. The clock generation sits outside the block and supplies each source as a one-cycle enable pulse in the system clock domain.

The counter either runs freely and wraps at the top of its range, or returns to zero after it reaches the RC compare value. The second mode gives a periodic tick. With stop-on-RC also set, the channel fires once and halts, which suits a one-shot delay. Compare matches against RA and RC can set and clear a waveform output pin. They also latch flags in a status register. Each flag can drive the interrupt line when its mask bit is set. Reading the status register clears the flags.

Software starts the channel with a command write that enables the clock and fires the trigger in one access. In periodic mode, software then waits for the interrupt. In one-shot mode, it reloads RC and triggers again for each delay.

Top module: `cmtc_channel`

## Requirements
- R1: After reset the count, status, interrupt mask, interrupt line and waveform output are all 0. The register map is MODE=0, CMD=1, RA=2, RC=3, COUNT=4 (read), STATUS=5 (read), IEN=6 (write sets mask bits, read returns mask) and IDIS=7 (write clears mask bits).
- R2: With MODE bit3=0 (free-running), each selected tick increments the count and RC never resets it. A tick at 0xFFFF wraps the count to 0 and sets STATUS bit2 (overflow).
- R3: With MODE bit3=1 (auto-reset), a selected tick while the count equals RC returns the count to 0 and sets STATUS bit1 (RC match). Counting then continues periodically.
- R4: With MODE bit4=1 (stop-on-RC) together with MODE bit3=1, the RC match also disables the clock. STATUS bit3 (running) reads 0 and later ticks leave the count at 0.
- R5: CMD bit0 enables counting and CMD bit1 disables it. When both bits are written in one access, disable wins. A later enable resumes counting from the held count.
- R6: CMD bit2 (software trigger) resets the count to 0. It starts counting only if the clock is enabled, either already or by bit0 in the same write.
- R7: A selected tick with the count equal to RA sets the waveform output when MODE bit5=1. A tick with the count equal to RC clears it when MODE bit6=1. When RA equals RC, the clear wins.
- R8: A STATUS read returns {running, overflow, RC match, RA match} in bits 3..0 and clears bits 2..0. A flag raised in the same cycle as the read is kept.
- R9: The interrupt line is high exactly while some STATUS flag in bits 2..0 is set with the matching mask bit set. Writing 0xFF to IDIS masks every source.
- R10: MODE bits 2..0 select the tick source. Values 0..3 select the prescaled ticks 0..3, 4 selects the slow tick, and 5..7 select external ticks 0..2. Ticks on unselected lines are ignored.
- R11: A selected tick while the count equals RA sets STATUS bit0 (RA match).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; `rdata` is valid one cycle later |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| presc_tick | input | 4 | Prescaled tick enables |
| slow_tick | input | 1 | Slow-clock tick enable |
| ext_tick | input | 3 | External chain tick enables |
| wave_out | output | 1 | Waveform output pin |
| irq | output | 1 | Interrupt request |

## Verification
The hardest condition to reach from the ports is the wrap from 0xFFFF. It needs 65,536 counted ticks, and the overflow flag must not be confused with the RA and RC flags raised on the way. The bench holds a prescaled tick line high for a long run of cycles. It reads the count just below the top of the range and clears the status there. A single further tick then isolates the overflow flag. The one-shot halt and the RA-equals-RC waveform conflict are reached in the same way: registers are reprogrammed while the count sits at a known value, then a precise number of ticks is driven.

// File: rtl/cmtc_pkg.sv
// Shared definitions for the compare-match timer counter channel.
// Assumes a 3-bit register address space and at most 8 tick sources.
package cmtc_pkg;
    localparam int ADDR_W = 3;
    localparam int SEL_W  = 3;
    localparam int FLAG_W = 3;   // 0: RA match, 1: RC match, 2: overflow

    typedef enum logic [ADDR_W-1:0] {
        A_MODE = 3'd0,
        A_CMD  = 3'd1,
        A_RA   = 3'd2,
        A_RC   = 3'd3,
        A_CNT  = 3'd4,
        A_STAT = 3'd5,
        A_IEN  = 3'd6,
        A_IDIS = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic             rc_clr;    // bit6
        logic             ra_set;    // bit5
        logic             stop_rc;   // bit4
        logic             auto_rst;  // bit3
        logic [SEL_W-1:0] sel;       // bits 2..0
    } mode_t;

    localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/cmtc_clk_mux.sv
// Tick source selector: presents the tick line picked by the select code.
// Assumes ticks are one-cycle enables in the clk domain. The order is
// prescaled, then slow, then external. Codes beyond the source count give no tick.
module cmtc_clk_mux #(
    parameter int N_PRESC = 4,
    parameter int N_EXT   = 3,
    parameter int SEL_W   = 3
) (
    input  logic [N_PRESC-1:0] presc_tick,
    input  logic               slow_tick,
    input  logic [N_EXT-1:0]   ext_tick,
    input  logic [SEL_W-1:0]   sel,
    output logic               tick
);
    localparam int N_SRC = N_PRESC + 1 + N_EXT;

    logic [N_SRC-1:0] src;
    assign src = {ext_tick, slow_tick, presc_tick};

    // Pick the selected source by index.
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (sel == SEL_W'(i)) tick = src[i];
        end
    end
endmodule

// File: rtl/cmtc_counter.sv
// Counter core: the count register, the clock-enable state and the compare events.
// Assumes the command bits are single-cycle pulses from a register write.
// Events are judged on the count held at the tick edge.
module cmtc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             auto_rst,
    input  logic             stop_rc,
    input  logic [CNT_W-1:0] ra,
    input  logic [CNT_W-1:0] rc,
    input  logic             cmd_en,
    input  logic             cmd_dis,
    input  logic             cmd_trig,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             ev_ra,
    output logic             ev_rc,
    output logic             ev_ovf
);
    logic adv;
    logic at_top;

    assign adv    = running && tick && !cmd_trig;
    assign at_top = (count == {CNT_W{1'b1}});
    assign ev_ra  = adv && (count == ra);
    assign ev_rc  = adv && (count == rc);
    assign ev_ovf = adv && at_top && !(auto_rst && (count == rc));

    // Count update: the trigger clears the count, otherwise it advances or restarts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (cmd_trig) begin
            count <= '0;
        end else if (adv) begin
            if (auto_rst && (count == rc)) count <= '0;
            else                           count <= count + CNT_W'(1);
        end
    end

    // Clock-enable state: disable beats enable, and a one-shot match stops the clock.
    always_ff @(posedge clk) begin
        if (!rst_n)                       running <= 1'b0;
        else if (cmd_dis)                 running <= 1'b0;
        else if (cmd_en)                  running <= 1'b1;
        else if (ev_rc && stop_rc && auto_rst) running <= 1'b0;
    end
endmodule

// File: rtl/cmtc_status.sv
// Status flags, interrupt mask and interrupt line.
// Assumes the read-clear pulse comes from a status read. Events in the same
// cycle as the clear are kept.
module cmtc_status #(
    parameter int FLAG_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] ev,
    input  logic              rd_clr,
    input  logic              ien_wr,
    input  logic              idis_wr,
    input  logic [FLAG_W-1:0] wmask,
    output logic [FLAG_W-1:0] flags,
    output logic [FLAG_W-1:0] mask,
    output logic              irq
);
    // Latch events; a status read clears the older flags.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~{FLAG_W{rd_clr}}) | ev;
    end

    // Mask update: IEN sets bits, IDIS clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else begin
            mask <= (mask | (ien_wr ? wmask : '0)) & ~(idis_wr ? wmask : '0);
        end
    end

    assign irq = |(flags & mask);
endmodule

// File: rtl/cmtc_channel.sv
// Top of the compare-match timer counter channel: register file, command
// decode, read mux and waveform output. Assumes single-cycle read and write
// strobes; read data is registered and valid the cycle after rd_en.
module cmtc_channel #(
    parameter int CNT_W   = 16,
    parameter int N_PRESC = 4,
    parameter int N_EXT   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [cmtc_pkg::ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]          wdata,
    output logic [CNT_W-1:0]          rdata,
    input  logic [N_PRESC-1:0]        presc_tick,
    input  logic                      slow_tick,
    input  logic [N_EXT-1:0]          ext_tick,
    output logic                      wave_out,
    output logic                      irq
);
    import cmtc_pkg::*;

    mode_t              mode_q;
    logic [CNT_W-1:0]   ra_q, rc_q, count;
    logic               tick, running;
    logic               ev_ra, ev_rc, ev_ovf;
    logic [FLAG_W-1:0]  flags, mask;
    logic               cmd_wr;

    assign cmd_wr = wr_en && (addr == A_CMD);

    // Configuration registers: mode and compare values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            ra_q   <= '0;
            rc_q   <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(addr))
                A_MODE:  mode_q <= mode_t'(wdata[MODE_W-1:0]);
                A_RA:    ra_q   <= wdata;
                A_RC:    rc_q   <= wdata;
                default: ;
            endcase
        end
    end

    cmtc_clk_mux #(.N_PRESC(N_PRESC), .N_EXT(N_EXT), .SEL_W(SEL_W)) mux_i (
        .presc_tick(presc_tick),
        .slow_tick (slow_tick),
        .ext_tick  (ext_tick),
        .sel       (mode_q.sel),
        .tick      (tick)
    );

    cmtc_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .auto_rst(mode_q.auto_rst),
        .stop_rc (mode_q.stop_rc),
        .ra      (ra_q),
        .rc      (rc_q),
        .cmd_en  (cmd_wr && wdata[0]),
        .cmd_dis (cmd_wr && wdata[1]),
        .cmd_trig(cmd_wr && wdata[2]),
        .count   (count),
        .running (running),
        .ev_ra   (ev_ra),
        .ev_rc   (ev_rc),
        .ev_ovf  (ev_ovf)
    );

    cmtc_status #(.FLAG_W(FLAG_W)) stat_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     ({ev_ovf, ev_rc, ev_ra}),
        .rd_clr (rd_en && (addr == A_STAT)),
        .ien_wr (wr_en && (addr == A_IEN)),
        .idis_wr(wr_en && (addr == A_IDIS)),
        .wmask  (wdata[FLAG_W-1:0]),
        .flags  (flags),
        .mask   (mask),
        .irq    (irq)
    );

    // Waveform pin: an RC clear beats an RA set.
    always_ff @(posedge clk) begin
        if (!rst_n)                         wave_out <= 1'b0;
        else if (ev_rc && mode_q.rc_clr)    wave_out <= 1'b0;
        else if (ev_ra && mode_q.ra_set)    wave_out <= 1'b1;
    end

    // Registered read mux.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= '0;
            case (reg_addr_e'(addr))
                A_MODE: rdata[MODE_W-1:0] <= mode_q;
                A_RA:   rdata <= ra_q;
                A_RC:   rdata <= rc_q;
                A_CNT:  rdata <= count;
                A_STAT: rdata[FLAG_W:0] <= {running, flags};
                A_IEN:  rdata[FLAG_W-1:0] <= mask;
                default: ;
            endcase
        end
    end
endmodule

// Property checker for the channel, attached by bind below.
module cmtc_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [2:0]       addr,
    input logic [CNT_W-1:0] wdata,
    input logic             irq,
    input logic             tick,
    input logic             running,
    input logic             auto_rst,
    input logic             stop_rc,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] rc,
    input logic [2:0]       flags
);
    // R2
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !auto_rst && count == {CNT_W{1'b1}} && !wr_en && !rd_en)
        |=> (count == '0 && flags[2]));

    // R3
    rc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && auto_rst && count == rc && !wr_en) |=> (count == '0));

    // R4
    oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && auto_rst && stop_rc && count == rc && !wr_en) |=> !running);

    // R5
    disable_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd1 && wdata[1]) |=> !running);

    // R6
    trigger_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd1 && wdata[2]) |=> (count == '0));

    // R8
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd5 && !(running && tick)) |=> (flags == 3'b000));

    // R9
    mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd7 && wdata[2:0] == 3'b111) |=> !irq);
endmodule

bind cmtc_channel cmtc_channel_chk #(.CNT_W(CNT_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .irq     (irq),
    .tick    (tick),
    .running (running),
    .auto_rst(mode_q.auto_rst),
    .stop_rc (mode_q.stop_rc),
    .count   (count),
    .rc      (rc_q),
    .flags   (flags)
);

// File: tb/cmtc_channel_tb_top.sv
// Directed bench for the compare-match timer counter channel.
module cmtc_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [3:0]  presc_tick = '0;
    logic        slow_tick = 1'b0;
    logic [2:0]  ext_tick = '0;
    logic        wave_out, irq;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    cmtc_channel dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .presc_tick(presc_tick),
        .slow_tick(slow_tick), .ext_tick(ext_tick), .wave_out(wave_out), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'(a); wdata = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        rd_en = 1'b1; addr = 3'(a);
        @(negedge clk);
        rd_en = 1'b0;
        d = int'(rdata);
    endtask

    // src 0..3 prescaled, 4 slow, 5..7 external; n ticks held high.
    task automatic ticks(input int src, input int n);
        @(negedge clk);
        if (src < 4)       presc_tick[src] = 1'b1;
        else if (src == 4) slow_tick = 1'b1;
        else               ext_tick[src-5] = 1'b1;
        repeat (n) @(negedge clk);
        presc_tick = '0; slow_tick = 1'b0; ext_tick = '0;
    endtask

    task automatic t_reset();
        int v;
        rd(4, v); check("R1 count", v, 0);
        rd(5, v); check("R1 status", v, 0);
        rd(6, v); check("R1 mask", v, 0);
        check("R1 irq", irq, 0);
        check("R1 wave", wave_out, 0);
    endtask

    task automatic t_free_wrap();
        int v;
        wr(2, 16'h0100); wr(3, 5); wr(0, 0); wr(1, 5);
        ticks(0, 10);
        rd(4, v); check("R2 rc ignored count", v, 10);
        rd(5, v); check("R2 status rc flag only", v, 'hA);
        wr(1, 4);
        ticks(0, 65535);
        rd(4, v); check("R2 count at top", v, 'hFFFF);
        rd(5, v); check("R11 ra flag on the way", v, 'hB);
        ticks(0, 1);
        rd(4, v); check("R2 wrap count", v, 0);
        rd(5, v); check("R2 overflow flag", v, 'hC);
    endtask

    task automatic t_auto();
        int v;
        wr(0, 'h08); wr(3, 3); wr(1, 4);
        ticks(0, 3);
        rd(4, v); check("R3 count at rc", v, 3);
        rd(5, v); check("R3 no flag yet", v, 'h8);
        ticks(0, 1);
        rd(4, v); check("R3 restart count", v, 0);
        rd(5, v); check("R3 rc flag", v, 'hA);
        rd(5, v); check("R8 read cleared", v, 'h8);
        ticks(0, 5);
        rd(4, v); check("R3 periodic count", v, 1);
    endtask

    task automatic t_oneshot();
        int v;
        rd(5, v);
        wr(6, 2); wr(0, 'h18); wr(3, 2); wr(1, 5);
        ticks(0, 2);
        check("R9 irq before match", irq, 0);
        ticks(0, 1);
        check("R9 irq on match", irq, 1);
        rd(5, v); check("R4 stopped status", v, 'h2);
        check("R8 irq drops after read", irq, 0);
        ticks(0, 5);
        rd(4, v); check("R4 held count", v, 0);
        wr(1, 5);
        ticks(0, 3);
        wr(7, 'hFF);
        check("R9 masked irq", irq, 0);
        rd(5, v); check("R9 flag still latched", v, 'h2);
    endtask

    task automatic t_cmd();
        int v;
        wr(0, 0); wr(2, 'h100); wr(3, 'h200); wr(1, 5);
        ticks(0, 4);
        rd(4, v); check("R6 enable+trigger start", v, 4);
        wr(1, 2); ticks(0, 4);
        rd(4, v); check("R5 disabled count", v, 4);
        rd(5, v); check("R5 running clear", v, 0);
        wr(1, 1); ticks(0, 2);
        rd(4, v); check("R5 resume count", v, 6);
        wr(1, 3); ticks(0, 3);
        rd(4, v); check("R5 disable wins", v, 6);
        wr(1, 4); ticks(0, 3);
        rd(4, v); check("R6 trigger alone", v, 0);
    endtask

    task automatic t_sel();
        int v;
        wr(0, 4); wr(1, 5);
        ticks(0, 3);
        rd(4, v); check("R10 presc ignored", v, 0);
        ticks(4, 3);
        rd(4, v); check("R10 slow counted", v, 3);
        wr(0, 6);
        ticks(5, 2);
        rd(4, v); check("R10 ext0 ignored", v, 3);
        ticks(6, 2);
        rd(4, v); check("R10 ext1 counted", v, 5);
        wr(0, 2);
        ticks(2, 1);
        rd(4, v); check("R10 presc2 counted", v, 6);
    endtask

    task automatic t_wave();
        int v;
        wr(0, 'h60); wr(2, 2); wr(3, 5); rd(5, v); wr(1, 5);
        ticks(0, 2);
        check("R7 wave low before ra", wave_out, 0);
        ticks(0, 1);
        check("R7 wave set on ra", wave_out, 1);
        rd(5, v); check("R11 ra flag", v, 'h9);
        ticks(0, 2);
        check("R7 wave holds", wave_out, 1);
        ticks(0, 1);
        check("R7 wave cleared on rc", wave_out, 0);
        wr(2, 0); wr(3, 9); wr(1, 4);
        ticks(0, 1);
        check("R7 wave set at zero", wave_out, 1);
        wr(2, 4); wr(3, 4);
        ticks(0, 3);
        check("R7 wave before tie", wave_out, 1);
        ticks(0, 1);
        check("R7 clear wins tie", wave_out, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_free_wrap();
        t_auto();
        t_oneshot();
        t_cmd();
        t_sel();
        t_wave();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule